// File: doc/BRIEF.md
# Gated Synchronous Clock Divider Bank

This block turns one input clock into three slower clocks at one half, one quarter and one eighth of its rate. All three come from a single synchronous counter. Every output changes on the same input rising edge, so the edges the outputs share line up exactly, with no ripple delay between stages.

A run input starts and stops the bank. It is captured by a two-state gate machine clocked on the falling input edge. The gated clock is the input clock ANDed with the gate state. Because the gate can only change while the input clock is low, the counter never sees a shortened clock pulse. An active-high asynchronous reset zeroes the counter and closes the gate. Several banks released from one reset line therefore step in lockstep.

The gate machine has two states. GATE_HALT blocks the clock and GATE_PASS lets it through. The transition T_START (HALT to PASS) is taken at a falling edge where run is high. The transition T_STOP (PASS to HALT) is taken at a falling edge where run is low. Reset forces GATE_HALT from either state.

Top module: `clk_div_bank`

## Requirements
- R1: The outputs form a 3-bit count {eighth_o, quarter_o, half_o}, with half_o as bit 0. The count rises by one, wrapping from 7 to 0, on every input rising edge at which the gate is open.
- R2: The stages are synchronous. quarter_o changes only on an edge where half_o falls. eighth_o changes only on an edge where quarter_o falls.
- R3: run_i is sampled only at falling input edges. A change of run_i between two falling edges has no effect until the next falling edge. A run_i pulse that starts and ends within one high phase is ignored.
- R4: While the gate is closed, all three outputs hold their levels and the count does not advance.
- R5: While rst_ai is high, all outputs read 0 and the gate is closed. Asserting rst_ai clears the outputs at once, without waiting for a clock edge.
- R6: If rst_ai is released during a high phase with run_i high, half_o stays 0 for the rest of that phase. half_o then rises on the first rising edge after the next falling edge.
- R7: No output ever shows a high or low pulse shorter than one input clock period, whatever the timing of run_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ai | input | 1 | Asynchronous active-high reset of counter and gate |
| run_i | input | 1 | Enable, sampled at falling clock edges |
| half_o | output | 1 | Input clock divided by 2 |
| quarter_o | output | 1 | Input clock divided by 4 |
| eighth_o | output | 1 | Input clock divided by 8 |

## Verification
The bench toggles run_i in the middle of high phases and low phases. A design that samples run_i on the rising edge, or that gates with the raw input, would advance one edge early or cut a high phase short. A pulse-width monitor and a cycle model catch both faults. A run_i pulse confined to one high phase must leave the count unchanged. A design using a level-sensitive enable would take an extra step there. After reset is released in a high phase, the first half_o rise must land on the second rising edge. Reset is also asserted in mid-cycle with a nonzero count, which would expose a reset that waits for a clock edge.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    // Number of divider stages (/2, /4, /8).
    localparam int STAGES = 3;

    // Clock gate state: blocked or passing.
    typedef enum logic {
        GATE_HALT = 1'b0,
        GATE_PASS = 1'b1
    } gate_state_e;

endpackage

// File: rtl/cdb_gate_fsm.sv
// Enable capture: a two-state machine updated on the falling clock edge,
// so its output only moves while the input clock is low.
module cdb_gate_fsm
    import cdb_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ai,
    input  logic run_i,
    output logic open_o
);

    gate_state_e state_q;
    gate_state_e state_d;

    // Next-state logic: T_START and T_STOP.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_HALT: if (run_i)  state_d = GATE_PASS; // T_START
            GATE_PASS: if (!run_i) state_d = GATE_HALT; // T_STOP
            default:               state_d = GATE_HALT;
        endcase
    end

    // State register on the falling edge, cleared asynchronously.
    always_ff @(negedge clk_i or posedge rst_ai) begin
        if (rst_ai) state_q <= GATE_HALT;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        open_o = (state_q == GATE_PASS);
    end

endmodule

// File: rtl/cdb_clk_gate.sv
// AND gate. It has no glitch because open_i only changes while clk_i is low.
module cdb_clk_gate (
    input  logic clk_i,
    input  logic open_i,
    output logic gclk_o
);

    always_comb begin
        gclk_o = clk_i & open_i;
    end

endmodule

// File: rtl/cdb_div_count.sv
// Synchronous up-counter. Each bit toggles when all lower bits are one,
// so every stage switches on the same gated edge.
module cdb_div_count #(
    parameter int STAGES = 3
) (
    input  logic              gclk_i,
    input  logic              rst_ai,
    output logic [STAGES-1:0] cnt_o
);

    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] carry;

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_lsb
            assign carry[gi] = 1'b1;
        end else begin : g_upper
            assign carry[gi] = carry[gi-1] & cnt_q[gi-1];
        end

        always_ff @(posedge gclk_i or posedge rst_ai) begin
            if (rst_ai)         cnt_q[gi] <= 1'b0;
            else if (carry[gi]) cnt_q[gi] <= ~cnt_q[gi];
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank (
    input  logic clk_i,
    input  logic rst_ai,
    input  logic run_i,
    output logic half_o,
    output logic quarter_o,
    output logic eighth_o
);

    import cdb_pkg::*;

    logic              gate_open;
    logic              gclk;
    logic [STAGES-1:0] cnt;

    cdb_gate_fsm gate_fsm_i (
        .clk_i  (clk_i),
        .rst_ai (rst_ai),
        .run_i  (run_i),
        .open_o (gate_open)
    );

    cdb_clk_gate clk_gate_i (
        .clk_i  (clk_i),
        .open_i (gate_open),
        .gclk_o (gclk)
    );

    cdb_div_count #(.STAGES(STAGES)) div_count_i (
        .gclk_i (gclk),
        .rst_ai (rst_ai),
        .cnt_o  (cnt)
    );

    assign half_o    = cnt[0];
    assign quarter_o = cnt[1];
    assign eighth_o  = cnt[2];

endmodule

// File: rtl/clk_div_bank_chk.sv
module clk_div_bank_chk (
    input logic clk_i,
    input logic rst_ai,
    input logic gate_open,
    input logic half_o,
    input logic quarter_o,
    input logic eighth_o
);

    logic [2:0] cnt_w;
    assign cnt_w = {eighth_o, quarter_o, half_o};

    // R1: an open gate steps the count by one.
    p_step_r1: assert property (@(posedge clk_i) disable iff (rst_ai)
        gate_open |=> (cnt_w == 3'($past(cnt_w) + 3'd1)))
        else $error("p_step_r1");

    // R2: each stage moves only when the stage below falls.
    p_align4_r2: assert property (@(posedge clk_i) disable iff (rst_ai)
        !$stable(quarter_o) |-> $fell(half_o))
        else $error("p_align4_r2");

    p_align8_r2: assert property (@(posedge clk_i) disable iff (rst_ai)
        !$stable(eighth_o) |-> $fell(quarter_o))
        else $error("p_align8_r2");

    // R4: a closed gate freezes the outputs.
    p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_ai)
        !gate_open |=> $stable(cnt_w))
        else $error("p_hold_r4");

    // R5: outputs are zero while reset is held.
    p_clear_r5: assert property (@(posedge clk_i)
        rst_ai |-> (cnt_w == 3'd0))
        else $error("p_clear_r5");

    // R3: the gate only changes while the input clock is low.
    always @(gate_open) begin
        if (!rst_ai) begin
            p_gate_low_r3: assert (clk_i == 1'b0)
                else $error("p_gate_low_r3");
        end
    end

endmodule

bind clk_div_bank clk_div_bank_chk chk_i (
    .clk_i     (clk_i),
    .rst_ai    (rst_ai),
    .gate_open (gate_open),
    .half_o    (half_o),
    .quarter_o (quarter_o),
    .eighth_o  (eighth_o)
);

// File: tb/clk_div_bank_tb_top.sv
`timescale 1ns/1ps
module clk_div_bank_tb_top;

    localparam real PERIOD = 20.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic half, quarter, eighth;
    logic [2:0] outs;
    int checks = 0;
    int fails  = 0;
    int short_pulses = 0;

    assign outs = {eighth, quarter, half};

    always #10 clk = ~clk;

    clk_div_bank dut_i (
        .clk_i     (clk),
        .rst_ai    (rst),
        .run_i     (run),
        .half_o    (half),
        .quarter_o (quarter),
        .eighth_o  (eighth)
    );

    // Pulse-width monitor for R7.
    realtime last_t [3];
    logic    armed  [3];
    logic [2:0] prev_outs = 3'b000;
    always @(outs or rst) begin
        for (int i = 0; i < 3; i++) begin
            if (outs[i] != prev_outs[i]) begin
                if (!rst && armed[i] && ($realtime - last_t[i]) < PERIOD)
                    short_pulses++;
                last_t[i] = $realtime;
                armed[i]  = !rst;
            end
            if (rst) armed[i] = 1'b0;
        end
        prev_outs = outs;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #4 rst = 1'b1;
        repeat (2) @(posedge clk);
        #3 rst = 1'b0;
    endtask

    // R5: outputs are zero during reset.
    task automatic t_reset_state();
        @(posedge clk); #5;
        check(outs == 3'd0, "R5 reset state", outs, 0);
    endtask

    // R6 then R1: first rise after release, then the full count sequence.
    task automatic t_first_edge_and_count();
        run = 1'b1;
        @(posedge clk); #3 rst = 1'b0;        // released in the high phase
        #2 check(half == 1'b0, "R6 no rise in release phase", half, 0);
        @(posedge clk); #5;                   // one falling edge passed
        check(half == 1'b1, "R6 first half_o rise", half, 1);
        for (int k = 2; k <= 17; k++) begin
            @(posedge clk); #5;
            check(outs == 3'(k % 8), "R1 count sequence", outs, k % 8);
        end
    endtask

    // R4: run dropped in a high phase; count freezes from the next edge on.
    task automatic t_hold();
        logic [2:0] c;
        @(posedge clk); #3 run = 1'b0;
        #2 c = outs;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #5;
            check(outs == c, "R4 hold while disabled", outs, c);
        end
    endtask

    // R3: a run pulse inside one high phase is ignored; a low-phase change
    // waits for the next falling edge.
    task automatic t_sample_edge();
        logic [2:0] c;
        c = outs;
        @(posedge clk); #3 run = 1'b1; #4 run = 1'b0;
        repeat (3) @(posedge clk);
        #5 check(outs == c, "R3 high-phase pulse ignored", outs, c);
        @(negedge clk); #5 run = 1'b1;
        @(posedge clk); #5;
        check(outs == c, "R3 low-phase change deferred", outs, c);
        @(posedge clk); #5;
        check(outs == 3'(c + 3'd1), "R3 gate open after falling edge", outs, 3'(c + 3'd1));
    endtask

    // R5: asynchronous clear with a nonzero count.
    task automatic t_async_reset();
        while (outs == 3'd0) begin
            @(posedge clk); #5;
        end
        @(posedge clk); #4 rst = 1'b1;
        #1 check(outs == 3'd0, "R5 immediate clear", outs, 0);
        repeat (2) begin
            @(posedge clk); #5;
            check(outs == 3'd0, "R5 held in reset", outs, 0);
        end
    endtask

    // R2, R7: random run timing in both phases against a cycle model.
    task automatic t_random_toggle();
        logic [2:0] model;
        logic       gate;
        int         bad;
        logic [2:0] prev;
        model = 3'd0; gate = 1'b0; bad = 0;
        run = 1'b0;
        do_reset();
        @(posedge clk); #1;
        prev = outs;
        for (int n = 0; n < 500; n++) begin
            #($urandom_range(1, 8));
            if ($urandom_range(0, 2) == 0) run = ~run;
            @(negedge clk);
            gate = run;
            #($urandom_range(1, 8));
            if ($urandom_range(0, 2) == 0) run = ~run;
            @(posedge clk);
            if (gate) model = model + 3'd1;
            #1;
            if (outs != model) bad++;
            if (outs[1] != prev[1] && !(prev[0] && !outs[0])) bad++;
            if (outs[2] != prev[2] && !(prev[1] && !outs[1])) bad++;
            prev = outs;
        end
        check(bad == 0, "R2 aligned stages under random run", bad, 0);
        check(short_pulses == 0, "R7 no short pulse", short_pulses, 0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_first_edge_and_count();
        t_hold();
        t_sample_edge();
        t_async_reset();
        rst = 1'b0;
        t_random_toggle();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule